// File: doc/BRIEF.md
# Divided-Clock Register Access Bridge

This block connects a processor's register bus, running on the system clock, to a bank of peripheral registers that run on a slower clock. The slower clock is the system clock divided by 1, 2, 4 or 8. Writes from the processor are registered and forwarded to the peripheral side. A clock-enable pulse marks each slow-domain edge. Reads, and read-modify-write accesses, are looked up combinationally in the peripheral bank.

A freshly written value needs a few system cycles to reach the slow domain. During that time a read of the same register would return the old contents. The bridge therefore remembers the last written address and runs a settle counter, loaded with the divider minus one on every write.

An access to that address while the counter is still running raises a hazard indication. When stalling is enabled it also holds the processor off until the count reaches zero. Accesses to any other register are never delayed.

Top module: `sfr_div_bridge`

## Requirements
- R1: After reset the divider is 1 (per_ce_o pulses every cycle), nothing is pending, and stall_o and hazard_o are low.
- R2: div_sel_i encodes the divider as 0→1, 1→2, 2→4, 3→8; per_ce_o then pulses once every divider cycles.
- R3: With the divider at 1, a read of a register in the cycle right after writing it is not stalled.
- R4: With the divider at 2, 4 or 8, a read of the address written in the previous cycle stalls for 1, 3 or 7 cycles respectively, and stall_o stays high until the settle count reaches zero.
- R5: During a pending write, reads of any other address are neither stalled nor flagged.
- R6: Writes are never stalled; one cycle after wr_en_i, per_wr_o pulses with the written address and data on per_waddr_o and per_wdata_o.
- R7: A read-modify-write strobe (rmw_en_i) is blocked exactly like a plain read.
- R8: A new write while a count is running restarts the count at the full value and makes the new address the blocked one; the previous address is released.
- R9: A change of div_sel_i is taken only on a clock edge with nothing pending and no write; while a write is pending the running count keeps the old divider.
- R10: hazard_o is high on every cycle a blocked access is presented; with STALL_EN=0, stall_o stays low while hazard_o still flags the access.
- R11: per_raddr_o follows addr_i and rdata_o follows per_rdata_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel_i | input | 2 | Peripheral divider select (0:/1, 1:/2, 2:/4, 3:/8) |
| wr_en_i | input | 1 | Processor write strobe |
| rd_en_i | input | 1 | Processor read strobe |
| rmw_en_i | input | 1 | Processor read-modify-write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data returned to the processor |
| stall_o | output | 1 | Hold the current access |
| hazard_o | output | 1 | Access targets a register whose write has not settled |
| per_ce_o | output | 1 | Slow-domain clock enable |
| per_wr_o | output | 1 | Forwarded write strobe |
| per_waddr_o | output | AW | Forwarded write address |
| per_wdata_o | output | DW | Forwarded write data |
| per_raddr_o | output | AW | Read address into the peripheral bank |
| per_rdata_i | input | DW | Read data from the peripheral bank |

## Verification
The bench measures the stall length of a read that follows a write back to back, for every divider. An off-by-one counter load would show up as a stall one cycle too long or too short. A write that replaces the tracked address mid-count must release the old address and block the new one for the full count. A design that kept the first address, or did not reload, would stall the wrong read or stall too briefly. A divider change requested while a write is pending must not cut the running count short, and must apply to the following write. A second instance with stalling disabled checks that the hazard flag still fires when no stall is raised.

// File: rtl/sfr_div_pkg.sv
package sfr_div_pkg;

    localparam int DIV_SEL_W = 2;
    localparam int CNT_W     = 3;

    typedef enum logic [DIV_SEL_W-1:0] {
        DIV_BY1 = 2'd0,
        DIV_BY2 = 2'd1,
        DIV_BY4 = 2'd2,
        DIV_BY8 = 2'd3
    } div_sel_e;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] left;
    } settle_t;

    // system cycles of settle time after a write: divider minus one
    function automatic logic [CNT_W-1:0] settle_cycles(div_sel_e d);
        logic [CNT_W:0] one;
        logic [CNT_W:0] full;
        one  = {{CNT_W{1'b0}}, 1'b1};
        full = (one << d) - one;
        return full[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/sfr_div_clkgen.sv
module sfr_div_clkgen
    import sfr_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_sel_e div_sel_i,
    input  logic     idle_i,
    output div_sel_e div_q_o,
    output logic     ce_o
);

    div_sel_e         div_q;
    logic [CNT_W-1:0] phase;
    logic [CNT_W-1:0] last_phase;

    assign last_phase = settle_cycles(div_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= DIV_BY1;
            phase <= '0;
        end else if (idle_i && (div_sel_i != div_q)) begin
            div_q <= div_sel_i;
            phase <= '0;
        end else if (phase == last_phase) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign div_q_o = div_q;
    assign ce_o    = (phase == last_phase);

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !idle_i |=> $stable(div_q)); // R9

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        phase <= last_phase); // R2

endmodule

// File: rtl/sfr_wr_tracker.sv
module sfr_wr_tracker
    import sfr_div_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [CNT_W-1:0] load_i,
    output logic [AW-1:0]    trk_addr_o,
    output settle_t          st_o
);

    logic [AW-1:0]    trk_addr;
    logic [CNT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_addr <= '0;
            left     <= '0;
        end else if (wr_i) begin
            trk_addr <= addr_i;
            left     <= load_i;
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign trk_addr_o = trk_addr;
    assign st_o.left  = left;
    assign st_o.busy  = (left != '0);

    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (st_o.left == $past(load_i)) && (trk_addr_o == $past(addr_i))); // R8

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!wr_i && st_o.busy) |=> (st_o.left == $past(st_o.left) - 1'b1)); // R4

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(trk_addr_o)); // R8

endmodule

// File: rtl/sfr_hazard_gate.sv
module sfr_hazard_gate
    import sfr_div_pkg::*;
#(
    parameter int AW       = 8,
    parameter bit STALL_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] trk_addr_i,
    input  settle_t       st_i,
    output logic          hazard_o,
    output logic          stall_o
);

    logic blocked;

    assign blocked  = acc_i && st_i.busy && (addr_i == trk_addr_i);
    assign hazard_o = blocked;

    generate
        if (STALL_EN) begin : g_stall
            assign stall_o = blocked;
        end else begin : g_flag_only
            assign stall_o = 1'b0;
        end
    endgenerate

    AST_FREE_WHEN_SETTLED: assert property (@(posedge clk) disable iff (rst)
        !st_i.busy |-> !hazard_o && !stall_o); // R4

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (stall_o && st_i.left > 1 && $stable(addr_i)) |=>
            (!acc_i || stall_o)); // R4

    AST_NO_STALL_FLAG_MODE: assert property (@(posedge clk) disable iff (rst)
        !STALL_EN |-> !stall_o); // R10

endmodule

// File: rtl/sfr_div_bridge.sv
module sfr_div_bridge
    import sfr_div_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter bit STALL_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    div_sel_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic          rmw_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          stall_o,
    output logic          hazard_o,
    output logic          per_ce_o,
    output logic          per_wr_o,
    output logic [AW-1:0] per_waddr_o,
    output logic [DW-1:0] per_wdata_o,
    output logic [AW-1:0] per_raddr_o,
    input  logic [DW-1:0] per_rdata_i
);

    div_sel_e      div_q;
    settle_t       st;
    logic [AW-1:0] trk_addr;
    logic          idle;
    logic          acc;

    logic          wr_q;
    logic [AW-1:0] waddr_q;
    logic [DW-1:0] wdata_q;

    assign idle = !st.busy && !wr_en_i;
    assign acc  = rd_en_i || rmw_en_i;

    sfr_div_clkgen u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .div_sel_i (div_sel_e'(div_sel_i)),
        .idle_i    (idle),
        .div_q_o   (div_q),
        .ce_o      (per_ce_o)
    );

    sfr_wr_tracker #(.AW(AW)) u_tracker (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (wr_en_i),
        .addr_i     (addr_i),
        .load_i     (settle_cycles(div_q)),
        .trk_addr_o (trk_addr),
        .st_o       (st)
    );

    sfr_hazard_gate #(.AW(AW), .STALL_EN(STALL_EN)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .acc_i      (acc),
        .addr_i     (addr_i),
        .trk_addr_i (trk_addr),
        .st_i       (st),
        .hazard_o   (hazard_o),
        .stall_o    (stall_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            waddr_q <= '0;
            wdata_q <= '0;
        end else begin
            wr_q <= wr_en_i;
            if (wr_en_i) begin
                waddr_q <= addr_i;
                wdata_q <= wdata_i;
            end
        end
    end

    assign per_wr_o    = wr_q;
    assign per_waddr_o = waddr_q;
    assign per_wdata_o = wdata_q;
    assign per_raddr_o = addr_i;
    assign rdata_o     = per_rdata_i;

    AST_DIV1_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        (div_q == DIV_BY1) |-> !st.busy); // R3

    AST_OTHER_ADDR_FREE: assert property (@(posedge clk) disable iff (rst)
        (acc && addr_i != trk_addr) |-> !hazard_o && !stall_o); // R5

    AST_WRITE_FORWARD: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> per_wr_o && (per_waddr_o == $past(addr_i))
                    && (per_wdata_o == $past(wdata_i))); // R6

    AST_STALL_IMPLIES_HAZARD: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> hazard_o); // R10

endmodule

// File: tb/sfr_div_bridge_tb.sv
module sfr_div_bridge_tb;

    localparam int AW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    div_sel = 2'd0;
    logic          wr_en = 1'b0, rd_en = 1'b0, rmw_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] per_rdata = '0;

    logic [DW-1:0] rdata, f_rdata;
    logic          stall, hazard, per_ce, per_wr;
    logic [AW-1:0] per_waddr, per_raddr, f_waddr, f_raddr;
    logic [DW-1:0] per_wdata, f_wdata;
    logic          f_stall, f_hazard, f_ce, f_wr;

    int tests = 0;
    int fails = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    sfr_div_bridge #(.AW(AW), .DW(DW), .STALL_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .div_sel_i(div_sel), .wr_en_i(wr_en),
        .rd_en_i(rd_en), .rmw_en_i(rmw_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .stall_o(stall), .hazard_o(hazard), .per_ce_o(per_ce),
        .per_wr_o(per_wr), .per_waddr_o(per_waddr), .per_wdata_o(per_wdata),
        .per_raddr_o(per_raddr), .per_rdata_i(per_rdata)
    );

    sfr_div_bridge #(.AW(AW), .DW(DW), .STALL_EN(1'b0)) u_flag (
        .clk(clk), .rst(rst), .div_sel_i(div_sel), .wr_en_i(wr_en),
        .rd_en_i(rd_en), .rmw_en_i(rmw_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(f_rdata), .stall_o(f_stall), .hazard_o(f_hazard), .per_ce_o(f_ce),
        .per_wr_o(f_wr), .per_waddr_o(f_waddr), .per_wdata_o(f_wdata),
        .per_raddr_o(f_raddr), .per_rdata_i(per_rdata)
    );

    task automatic check(string req, int act, int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // scoreboard: driver side pushes expectations, monitor side pops and compares
    task automatic expect_push(int v);
        exp_q.push_back(v);
    endtask

    task automatic monitor_pop(string req, int act);
        int e;
        if (exp_q.size() == 0) begin
            check(req, act, -1);
        end else begin
            e = exp_q.pop_front();
            check(req, act, e);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        wr_en = 0; rd_en = 0; rmw_en = 0;
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 0; rmw_en = 0; wr_en = 1; addr = a; wdata = d;
    endtask

    task automatic set_div(logic [1:0] s);
        @(negedge clk);
        wr_en = 0; rd_en = 0; rmw_en = 0; div_sel = s;
        @(negedge clk);
    endtask

    // present a read (or rmw) and count the cycles it is held off
    task automatic measure(logic [AW-1:0] a, bit use_rmw, output int n,
                           output int first_flag_hz, output int first_flag_st);
        n = 0;
        @(negedge clk);
        wr_en = 0; addr = a; rd_en = !use_rmw; rmw_en = use_rmw;
        #2;
        first_flag_hz = f_hazard;
        first_flag_st = f_stall;
        for (int k = 0; k < 20; k++) begin
            if (!stall) break;
            if (!hazard) check("R10 hazard during stall", 0, 1);
            n++;
            @(negedge clk);
            #2;
        end
    endtask

    task automatic count_ce(int window, output int pulses);
        pulses = 0;
        for (int k = 0; k < window; k++) begin
            @(negedge clk);
            #2;
            if (per_ce) pulses++;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int n, fh, fs, p;
        repeat (3) @(negedge clk);
        rst = 0;
        #2;
        // R1 reset state
        check("R1 stall after reset", stall, 0);
        check("R1 hazard after reset", hazard, 0);
        count_ce(4, p);
        check("R1 divider 1 after reset", p, 4);

        // R2 divider encodings
        for (int s = 0; s < 4; s++) begin
            set_div(s[1:0]);
            count_ce(16, p);
            expect_push(16 >> s);
            monitor_pop("R2 ce pulses per 16 cycles", p);
        end

        // R3 divider 1, immediate read
        set_div(2'd0);
        do_write(8'h11, 8'hA1);
        measure(8'h11, 0, n, fh, fs);
        expect_push(0);
        monitor_pop("R3 no stall at divider 1", n);

        // R4 stall lengths for /2, /4, /8
        for (int s = 1; s < 4; s++) begin
            set_div(s[1:0]);
            do_write(8'h20, 8'h5A);
            measure(8'h20, 0, n, fh, fs);
            expect_push((1 << s) - 1);
            monitor_pop("R4 stall cycles", n);
        end

        // R6 write forwarding and R7 rmw blocking at /4
        set_div(2'd2);
        do_write(8'h33, 8'hC3);
        @(negedge clk);
        wr_en = 0; rmw_en = 1; addr = 8'h33;
        #2;
        check("R6 per_wr pulse", per_wr, 1);
        check("R6 forwarded address", per_waddr, 8'h33);
        check("R6 forwarded data", per_wdata, 8'hC3);
        check("R7 rmw stalled", stall, 1);
        check("R10 flag-only mode stall low", f_stall, 0);
        check("R10 flag-only mode hazard high", f_hazard, 1);
        repeat (4) idle_cycle();

        // R5 other address during pending, R11 read path
        set_div(2'd3);
        do_write(8'h40, 8'h01);
        @(negedge clk);
        wr_en = 0; rd_en = 1; addr = 8'h41; per_rdata = 8'h9E;
        #2;
        check("R5 other address not stalled", stall, 0);
        check("R5 other address not flagged", hazard, 0);
        check("R11 read address", per_raddr, 8'h41);
        check("R11 read data", rdata, 8'h9E);
        repeat (8) idle_cycle();

        // R8 rewrite mid-count reloads and moves the blocked address
        do_write(8'h50, 8'h02);
        repeat (3) idle_cycle();
        do_write(8'h51, 8'h03);
        measure(8'h51, 0, n, fh, fs);
        expect_push(7);
        monitor_pop("R8 full reload on new address", n);
        do_write(8'h51, 8'h04);
        measure(8'h50, 0, n, fh, fs);
        expect_push(0);
        monitor_pop("R8 old address released", n);
        repeat (8) idle_cycle();

        // R9 divider change held off while pending
        set_div(2'd1);
        do_write(8'h60, 8'h05);
        @(negedge clk);
        div_sel = 2'd3; wr_en = 0; rd_en = 1; addr = 8'h60;
        n = 0;
        #2;
        for (int k = 0; k < 20; k++) begin
            if (!stall) break;
            n++;
            @(negedge clk);
            #2;
        end
        check("R9 old divider kept for pending write", n, 1);
        idle_cycle();
        do_write(8'h61, 8'h06);
        measure(8'h61, 0, n, fh, fs);
        check("R9 new divider applied after idle", n, 7);

        // R10 flag-only instance on a blocked read
        do_write(8'h62, 8'h07);
        measure(8'h62, 0, n, fh, fs);
        check("R10 flag-only hazard", fh, 1);
        check("R10 flag-only no stall", fs, 0);
        idle_cycle();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule